// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

This block is a synthesizable model of a clocked static RAM that serves short linear bursts. On each rising clock edge it samples three chip enables and two active-low address strobes. One strobe is meant for a processor and one for a memory controller. When a strobe finds the part selected, the block captures a start address. A two-bit counter on the lowest address bits then walks the burst, stepping whenever the active-low advance input is low. The upper address bits stay fixed for the whole burst.

Writes come in two forms. A global write stores every byte lane. A byte write is enabled by a shared enable and then stores only the lanes picked by their own active-low selects. Reads return registered data one cycle after the access. The data is qualified by an output-valid flag, which the asynchronous output enable gates directly. Instead of a tristate pin, the data bus is split into an input port and an output port plus the valid flag. The depth and the lane width are parameters, so a simulation can keep the array small.

Top module: `sbsram_top`

## Requirements
- R1: The part counts as selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. If a strobe is low while the part is not selected, the burst ends. `dout_vld` is then 0 after that edge, and it stays 0 until a new address is loaded.
- R2: While `cs1_n`=1, a low `pstb_n` is ignored. It loads no address and does not deselect the part. With `cstb_n`=1 and `adv_n`=1, an open burst keeps accessing its current address.
- R3: A strobe edge with the part selected loads the whole `addr` value. It performs the access at that address in the same edge. Read data appears on `dout` after that edge. `pstb_n` (when `cs1_n`=0) takes priority over `cstb_n`.
- R4: During a burst, an edge with no strobe and `adv_n`=0 adds one to address bits [1:0], wrapping from 3 to 0. It keeps the upper bits and accesses the new address.
- R5: During a burst, an edge with no strobe and `adv_n`=1 accesses the same address again.
- R6: `gwr_n`=0 writes all lanes of `din` to the access address, whatever the values of `bwen_n` and `lane_n`.
- R7: With `gwr_n`=1 and `bwen_n`=0, only the lanes whose `lane_n` bit is 0 are written. Bit 0 selects `din[7:0]` and bit 1 selects `din[15:8]`. With `gwr_n`=1 and `bwen_n`=1 the access is a read, and `lane_n` has no effect.
- R8: An edge that loads an address through `pstb_n` is always a read. The write controls are ignored in that edge.
- R9: `oe_n`=1 forces `dout_vld` to 0 at once, with no clock edge needed. `dout_vld` is 1 only after a read access with `oe_n`=0.
- R10: When a load starts a burst from the deselected state, the read that follows has `dout_vld`=0 even with `oe_n`=0. The next read in the burst is valid.
- R11: After reset the part is deselected and `dout_vld`=0. A write access gives `dout_vld`=0 after its edge. Write controls sampled while deselected with no strobe store nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | AW (10) | Start address, sampled on a strobe |
| cs1_n | input | 1 | Chip enable one, active low, also gates the processor strobe |
| cs2 | input | 1 | Chip enable two, active high |
| cs3_n | input | 1 | Chip enable three, active low |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write, active low |
| bwen_n | input | 1 | Byte write enable, active low |
| lane_n | input | LANES (2) | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | DW (16) | Write data |
| dout | output | DW (16) | Registered read data |
| dout_vld | output | 1 | Read data valid, gated by the output enable |

## Verification
Three functions can meet in one edge. A burst step, a lane-masked write and the first-read mask after deselect can all coincide, and so can a processor-strobe load and a write request. The scoreboard drives these pairs on purpose. A processor load is issued with global write held low, and a controller reload of the same address must later return the old data. A byte write is applied in the same cycle as a burst hold. Each of these is judged by the data and the valid flag that come back on the next read. The asynchronous enable is toggled between clock edges, and the valid flag is sampled without any intervening edge.

// File: rtl/sbsram_pkg.sv
// Package: shared control bundle and the burst-step helper.
// Assumes the burst counter is always two bits wide.
package sbsram_pkg;

    // Per-edge decoded command.
    typedef struct packed {
        logic load;     // selected strobe: capture addr
        logic desel;    // strobe while not selected
        logic proc;     // load came from processor strobe
        logic access;   // an array access happens this edge
        logic step;     // burst counter advances
        logic wr;       // access is a write
    } sb_ctl_t;

    // Which kind of write the lane decoder sees.
    typedef enum logic [1:0] {
        WK_NONE   = 2'd0,
        WK_GLOBAL = 2'd1,
        WK_BYTE   = 2'd2
    } wr_kind_e;

    // Linear modulo-4 step of the low address bits.
    function automatic logic [1:0] lo_next(input logic [1:0] lo);
        return lo + 2'd1;
    endfunction

endpackage

// File: rtl/sbsram_decode.sv
// Decodes chip enables, strobes and write controls into one command
// per edge. Purely combinational; assumes inputs are already synchronous.
module sbsram_decode
    import sbsram_pkg::*;
(
    input  logic    cs1_n,
    input  logic    cs2,
    input  logic    cs3_n,
    input  logic    pstb_n,
    input  logic    cstb_n,
    input  logic    adv_n,
    input  logic    gwr_n,
    input  logic    bwen_n,
    input  logic    busy,
    output sb_ctl_t ctl
);

    logic selected;
    logic p_go;
    logic c_go;
    logic strobe;

    // Select and strobe qualification; cs1_n also gates the processor strobe.
    always_comb begin
        selected = !cs1_n && cs2 && !cs3_n;
        p_go     = !pstb_n && !cs1_n;
        c_go     = !cstb_n;
        strobe   = p_go || c_go;
    end

    // Command bundle for this edge.
    always_comb begin
        ctl.load   = strobe && selected;
        ctl.desel  = strobe && !selected;
        ctl.proc   = p_go && selected;
        ctl.access = ctl.load || (!strobe && busy);
        ctl.step   = !strobe && busy && !adv_n;
        ctl.wr     = ctl.access && !ctl.proc && (!gwr_n || !bwen_n);
    end

endmodule

// File: rtl/sbsram_burst.sv
// Burst address keeper: holds the open/closed state and the current
// address, and forms the address the array uses this edge.
// Assumes AW >= 3 so that upper bits exist above the counter.
module sbsram_burst
    import sbsram_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          desel,
    input  logic          access,
    input  logic          step,
    input  logic [AW-1:0] addr,
    output logic          busy,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] eff_addr
);

    localparam int HI_W = AW - 2;

    logic [HI_W-1:0] cur_hi;
    logic [1:0]      cur_lo;

    assign cur_hi = cur_addr[AW-1:2];
    assign cur_lo = cur_addr[1:0];

    // Address used by this edge: fresh load, stepped or held.
    always_comb begin
        if (load)
            eff_addr = addr;
        else if (step)
            eff_addr = {cur_hi, lo_next(cur_lo)};
        else
            eff_addr = cur_addr;
    end

    // Burst open state: set by load, cleared by deselect.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy <= 1'b0;
        else if (load)
            busy <= 1'b1;
        else if (desel)
            busy <= 1'b0;
    end

    // Current address register follows each access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_addr <= '0;
        else if (access)
            cur_addr <= eff_addr;
    end

endmodule

// File: rtl/sbsram_lanes.sv
// Lane write-enable decoder: global write covers every lane, byte write
// covers the lanes whose active-low select is low.
module sbsram_lanes
    import sbsram_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             wr,
    input  logic             gwr_n,
    input  logic             bwen_n,
    input  logic [LANES-1:0] lane_n,
    output logic [LANES-1:0] lane_we
);

    wr_kind_e kind;

    // Classify the write; global overrides byte.
    always_comb begin
        if (!wr)
            kind = WK_NONE;
        else if (!gwr_n)
            kind = WK_GLOBAL;
        else if (!bwen_n)
            kind = WK_BYTE;
        else
            kind = WK_NONE;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Per-lane enable from the write kind.
        always_comb begin
            unique case (kind)
                WK_GLOBAL: lane_we[g] = 1'b1;
                WK_BYTE:   lane_we[g] = !lane_n[g];
                default:   lane_we[g] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/sbsram_array.sv
// Storage: one memory per byte lane with its own write enable and a
// registered read port. Contents are not reset.
module sbsram_array #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    parameter int DEPTH  = 1024,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        lane_we,
    input  logic                    rd_en,
    input  logic [AW-1:0]           addr,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout
);

    for (genvar g = 0; g < LANES; g++) begin : g_mem
        logic [LANE_W-1:0] mem [DEPTH];

        // Lane write.
        always_ff @(posedge clk) begin
            if (lane_we[g])
                mem[addr] <= din[g*LANE_W +: LANE_W];
        end

        // Lane read register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                dout[g*LANE_W +: LANE_W] <= '0;
            else if (rd_en)
                dout[g*LANE_W +: LANE_W] <= mem[addr];
        end
    end

endmodule

// File: rtl/sbsram_top.sv
// Synchronous burst SRAM model top. It ties the decoder, the burst
// keeper, the lane decoder and the storage together, and forms the
// read-valid flag, including the first-read mask after deselect.
// Assumes synchronous inputs except oe_n, which is asynchronous.
module sbsram_top
    import sbsram_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    parameter int DEPTH  = 1024,
    localparam int DW    = LANE_W * LANES,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             cs1_n,
    input  logic             cs2,
    input  logic             cs3_n,
    input  logic             pstb_n,
    input  logic             cstb_n,
    input  logic             adv_n,
    input  logic             gwr_n,
    input  logic             bwen_n,
    input  logic [LANES-1:0] lane_n,
    input  logic             oe_n,
    input  logic [DW-1:0]    din,
    output logic [DW-1:0]    dout,
    output logic             dout_vld
);

    sb_ctl_t          ctl;
    logic             busy;
    logic [AW-1:0]    cur_addr;
    logic [AW-1:0]    eff_addr;
    logic [LANES-1:0] lane_we;
    logic             rd_now;
    logic             rd_q;
    logic             first_q;

    sbsram_decode u_decode (
        .cs1_n  (cs1_n),
        .cs2    (cs2),
        .cs3_n  (cs3_n),
        .pstb_n (pstb_n),
        .cstb_n (cstb_n),
        .adv_n  (adv_n),
        .gwr_n  (gwr_n),
        .bwen_n (bwen_n),
        .busy   (busy),
        .ctl    (ctl)
    );

    sbsram_burst #(.AW(AW)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctl.load),
        .desel    (ctl.desel),
        .access   (ctl.access),
        .step     (ctl.step),
        .addr     (addr),
        .busy     (busy),
        .cur_addr (cur_addr),
        .eff_addr (eff_addr)
    );

    sbsram_lanes #(.LANES(LANES)) u_lanes (
        .wr      (ctl.wr),
        .gwr_n   (gwr_n),
        .bwen_n  (bwen_n),
        .lane_n  (lane_n),
        .lane_we (lane_we)
    );

    assign rd_now = ctl.access && !ctl.wr;

    sbsram_array #(
        .LANE_W (LANE_W),
        .LANES  (LANES),
        .DEPTH  (DEPTH),
        .AW     (AW)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_we (lane_we),
        .rd_en   (rd_now),
        .addr    (eff_addr),
        .din     (din),
        .dout    (dout)
    );

    // Read-state and first-read-mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q    <= 1'b0;
            first_q <= 1'b0;
        end else begin
            rd_q    <= rd_now;
            first_q <= ctl.load && !busy;
        end
    end

    // Valid flag, gated asynchronously by the output enable.
    assign dout_vld = rd_q && !first_q && !oe_n;

endmodule

// File: rtl/sbsram_chk.sv
// Checker for sbsram_top: temporal properties on ports and on the
// signals passed between the decoder, the burst keeper and the output.
module sbsram_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic          cs1_n,
    input logic          cstb_n,
    input logic          adv_n,
    input logic          oe_n,
    input logic          dout_vld,
    input logic          busy,
    input logic [AW-1:0] cur_addr,
    input logic          load,
    input logic          desel,
    input logic          access,
    input logic          step,
    input logic          wr,
    input logic          pstb_n
);

    logic no_strobe;
    assign no_strobe = cstb_n && (pstb_n || cs1_n);

    a_r1_desel_ends: assert property (@(posedge clk) disable iff (!rst_n)
        desel |=> (!busy && !dout_vld));

    a_r2_pstb_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cs1_n && cstb_n && adv_n) |=> ($stable(cur_addr) && $stable(busy)));

    a_r3_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (busy && cur_addr == $past(addr)));

    a_r4_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (no_strobe && busy && !adv_n) |=>
            (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1 &&
             cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (no_strobe && adv_n) |=> $stable(cur_addr));

    a_r9_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_vld);

    a_r10_first_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !busy) |=> !dout_vld);

    a_r11_write_no_vld: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !dout_vld);

    a_r11_idle_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load) |-> (!access && !step));

endmodule

bind sbsram_top sbsram_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .cs1_n    (cs1_n),
    .cstb_n   (cstb_n),
    .adv_n    (adv_n),
    .oe_n     (oe_n),
    .dout_vld (dout_vld),
    .busy     (busy),
    .cur_addr (cur_addr),
    .load     (ctl.load),
    .desel    (ctl.desel),
    .access   (ctl.access),
    .step     (ctl.step),
    .wr       (ctl.wr),
    .pstb_n   (pstb_n)
);

// File: tb/test_sbsram_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task applies one edge of stimulus, predicts
// the result from the requirements and queues it; the monitor pops and
// compares just after each rising edge.
module test_sbsram_top;

    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DEPTH  = 1024;
    localparam int DW     = LANE_W * LANES;
    localparam int AW     = $clog2(DEPTH);

    typedef struct {
        logic          vld;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [AW-1:0]    addr = '0;
    logic             cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1;
    logic             pstb_n = 1'b1, cstb_n = 1'b1, adv_n = 1'b1;
    logic             gwr_n = 1'b1, bwen_n = 1'b1;
    logic [LANES-1:0] lane_n = '1;
    logic             oe_n = 1'b1;
    logic [DW-1:0]    din = '0;
    logic [DW-1:0]    dout;
    logic             dout_vld;

    exp_t          q[$];
    int            errors = 0;
    int            checks = 0;
    bit            done = 1'b0;
    logic [DW-1:0] rmem [DEPTH];
    logic          r_busy = 1'b0;
    logic [AW-1:0] r_cur = '0;

    always #2.5 clk = ~clk;

    sbsram_top #(.LANE_W(LANE_W), .LANES(LANES), .DEPTH(DEPTH)) i_sbsram_top (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs1_n(cs1_n), .cs2(cs2),
        .cs3_n(cs3_n), .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n),
        .gwr_n(gwr_n), .bwen_n(bwen_n), .lane_n(lane_n), .oe_n(oe_n),
        .din(din), .dout(dout), .dout_vld(dout_vld)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [DW:0] act, input logic [DW:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One edge of stimulus plus its predicted result.
    task automatic drive(input logic c1n, input logic c2, input logic c3n,
                         input logic pn, input logic cn, input logic avn,
                         input logic gwn, input logic bwn_en,
                         input logic [LANES-1:0] ln, input logic oen,
                         input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input string tag);
        logic sel, pgo, strobe, load, acc, wr;
        logic [AW-1:0] eff;
        exp_t e;
        cs1_n = c1n; cs2 = c2; cs3_n = c3n; pstb_n = pn; cstb_n = cn;
        adv_n = avn; gwr_n = gwn; bwen_n = bwn_en; lane_n = ln;
        oe_n = oen; addr = a; din = d;
        sel    = !c1n && c2 && !c3n;
        pgo    = !pn && !c1n;
        strobe = pgo || !cn;
        load   = strobe && sel;
        acc    = load || (!strobe && r_busy);
        wr     = acc && !(pgo && sel) && (!gwn || !bwn_en);
        eff    = load ? a : (!strobe && !avn) ? {r_cur[AW-1:2], r_cur[1:0] + 2'd1} : r_cur;
        if (wr) begin
            for (int l = 0; l < LANES; l++)
                if (!gwn || !ln[l])
                    rmem[eff][l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
        end
        e.vld  = acc && !wr && !(load && !r_busy) && !oen;
        e.data = rmem[eff];
        e.tag  = tag;
        q.push_back(e);
        if (acc) r_cur = eff;
        if (load) r_busy = 1'b1;
        else if (strobe && !sel) r_busy = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: compares the result of each edge against the queue head.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            if (e.vld)
                check(dout_vld === 1'b1 && dout === e.data, e.tag,
                      {dout_vld, dout}, {1'b1, e.data});
            else
                check(dout_vld === 1'b0, e.tag, {dout_vld, dout}, {1'b0, e.data});
        end
    end

    // Watchdog.
    initial begin
        #1ms;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) rmem[i] = 'x;
        repeat (3) @(negedge clk);
        check(dout_vld === 1'b0, "R11 reset", {dout_vld, dout}, '0);
        rst_n = 1'b1;
        // Global-write burst with wrap: 012,013,010,011 (R4, R6).
        drive(0,1,0,1,0,1,0,1,2'b11,0,10'h012,16'hA0B0,"R6 load write");
        drive(0,1,0,1,1,0,0,1,2'b11,0,10'h000,16'hA1B1,"R4 step write");
        drive(0,1,0,1,1,0,0,1,2'b11,0,10'h000,16'hA2B2,"R4 wrap write");
        drive(0,1,0,1,1,0,0,1,2'b11,0,10'h000,16'hA3B3,"R4 step write2");
        drive(0,0,0,1,0,1,1,1,2'b11,0,10'h000,16'h0000,"R1 desel cs2");
        // Processor load with write held low: read, first masked (R8, R10).
        drive(0,1,0,0,1,1,0,0,2'b00,0,10'h012,16'hDEAD,"R10 first masked");
        drive(0,1,0,1,1,0,1,1,2'b11,0,10'h000,16'h0000,"R4 step read");
        drive(0,1,0,1,1,0,1,1,2'b11,0,10'h000,16'h0000,"R4 wrap read");
        drive(0,1,0,1,1,1,1,1,2'b11,0,10'h000,16'h0000,"R5 hold read");
        // Asynchronous output enable between edges (R9).
        #0.5 oe_n = 1'b1; #0.5;
        check(dout_vld === 1'b0, "R9 async off", {dout_vld, dout}, '0);
        oe_n = 1'b0; #0.5;
        check(dout_vld === 1'b1, "R9 async on", {dout_vld, dout}, {1'b1, dout});
        @(negedge clk);
        drive(0,1,0,1,1,1,1,1,2'b11,1,10'h000,16'h0000,"R9 oe high");
        drive(0,1,0,1,0,1,1,1,2'b11,0,10'h012,16'h0000,"R8 R3 reload");
        // Byte lanes (R6, R7).
        drive(0,1,0,1,0,1,0,1,2'b11,0,10'h100,16'hCAFE,"R6 full write");
        drive(0,1,0,1,1,1,1,0,2'b10,0,10'h000,16'h1122,"R7 lane A");
        drive(0,1,0,1,1,1,1,0,2'b01,0,10'h000,16'h3344,"R7 lane B");
        drive(0,1,0,1,1,1,1,0,2'b11,0,10'h000,16'h5555,"R7 no lanes");
        drive(0,1,0,1,1,1,1,1,2'b00,0,10'h000,16'h7777,"R7 bwen high read");
        drive(0,1,0,1,1,1,0,0,2'b11,0,10'h000,16'hBEEF,"R6 override");
        drive(0,1,0,1,1,1,1,1,2'b11,0,10'h000,16'h0000,"R6 readback");
        drive(1,1,0,0,1,1,1,1,2'b11,0,10'h200,16'h0000,"R2 pstb ignored");
        drive(0,0,0,0,1,1,1,1,2'b11,0,10'h000,16'h0000,"R1 desel pstb");
        drive(0,1,0,1,1,0,0,1,2'b11,0,10'h100,16'h0000,"R11 idle write");
        drive(0,1,0,1,0,1,1,1,2'b11,0,10'h100,16'h0000,"R10 mask again");
        drive(0,1,0,1,1,1,1,1,2'b11,0,10'h000,16'h0000,"R11 R10 next valid");
        drive(0,1,1,1,0,1,1,1,2'b11,0,10'h000,16'h0000,"R1 desel cs3");
        drive(1,1,0,0,1,1,1,1,2'b11,0,10'h011,16'h0000,"R2 idle ignored");
        drive(0,1,0,1,0,1,1,1,2'b11,0,10'h011,16'h0000,"R3 load read");
        drive(0,1,0,1,1,0,1,1,2'b11,0,10'h000,16'h0000,"R4 step 012");
        drive(0,1,0,1,1,0,1,1,2'b11,0,10'h000,16'h0000,"R4 step 013");
        drive(1,1,0,1,0,1,1,1,2'b11,0,10'h000,16'h0000,"R1 desel cs1");
        drive(0,1,0,1,1,0,1,1,2'b11,0,10'h000,16'h0000,"R1 stays idle");
        drive(0,1,0,1,1,1,1,1,2'b11,0,10'h000,16'h0000,"R1 drain");
        @(negedge clk);
        if (q.size() != 0)
            check(1'b0, "R3 queue", {1'b0, 16'(q.size())}, '0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule